// File: doc/BRIEF.md
# Non-Pipelined Bus Cycle Sequencer

This block turns single transfer requests from inside the chip into bus cycles on a simple external processor bus. A requester offers an address, byte enables, a direction flag, a memory/IO flag and write data over a valid/ready handshake. The block then runs the bus through one address state and one or more data states. It finishes the cycle when the external system pulls its active-low ready input low at the end of a data state. It returns a one-clock done pulse and, for reads, the captured data word.

The external system sets the speed of every cycle through the timing of its ready signal. The shortest cycle is one address state followed by one data state. Each data state that ends with ready high is repeated, and each repeat counts as one wait state. There is no upper bound on the number of wait states. The ready level at the end of the address state has no effect. If another request is waiting when a cycle finishes, the next address state follows directly. Otherwise the bus goes idle.

The request side applies back-pressure. `req_ready` is high only while the bus is idle, or during the data state that the external system is ending in that clock. A requester must hold `req_valid` and all request fields stable until it sees `req_valid && req_ready` at a clock edge. That edge is the acceptance point.

Top module: `bus_cyc_ctrl`

## Requirements
- R1: After reset the bus is idle: `bus_astb`, `bus_data_ph`, `bus_doe` and `rsp_done` are low, and `req_ready` is high.
- R2: Every accepted request produces exactly one address state (`bus_astb` high for one clock), beginning in the clock after acceptance. The data state (`bus_data_ph` high) follows immediately.
- R3: The level of `bus_rdy_n` during the address state is ignored. The cycle always moves on to a data state.
- R4: A data state in which `bus_rdy_n` is high at its closing edge is followed by another data state. The number of data states equals the wait count plus one.
- R5: `bus_addr`, `bus_be`, `bus_wr` and `bus_io` equal the accepted request from the address state through the final data state, and do not change between them. `bus_wr`=1 means write and `bus_io`=1 means IO space.
- R6: During every data state of a write, `bus_doe` is high and `bus_dout` carries the request's write data. `bus_doe` is low in all other states.
- R7: For a read, `rsp_rdata` holds the value of `bus_din` sampled at the edge where `bus_rdy_n` is low in a data state. Values on `bus_din` in earlier data states are not used.
- R8: `rsp_done` is high for exactly one clock, in the clock after the terminating edge. It is never high at any other time.
- R9: `req_ready` is high exactly when the bus is idle, or when it is in a data state with `bus_rdy_n` low. A request accepted on the terminating data state gets its address state in the very next clock, with no idle state in between.
- R10: When no request is accepted on the terminating edge, the bus is idle (no strobe high) in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted this clock |
| req_addr | input | ADDR_W | Transfer address |
| req_be | input | DATA_W/8 | Byte enables, active high |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = IO space, 0 = memory space |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with and after `rsp_done` |
| bus_addr | output | ADDR_W | Bus address |
| bus_be | output | DATA_W/8 | Bus byte enables |
| bus_wr | output | 1 | Bus direction indicator |
| bus_io | output | 1 | Bus memory/IO indicator |
| bus_astb | output | 1 | High during the address state |
| bus_data_ph | output | 1 | High during each data state |
| bus_dout | output | DATA_W | Write data toward the bus |
| bus_doe | output | 1 | Write data output enable |
| bus_din | input | DATA_W | Read data from the bus |
| bus_rdy_n | input | 1 | Active-low cycle ready from the external system |

## Verification
The bench instantiates the block with its default widths: a 24-bit address and a 16-bit data word with two byte enables. This is wide enough that a mixed-up or partially latched address field, or a swapped byte of data, shows up as a mismatch. The responder picks wait counts from zero to five and adds a directed nine-wait cycle. This exercises the smallest two-state cycle as well as long wait tails. Random gaps between requests, including none at all, cover both the back-to-back start on the terminating data state and the return to idle.

// File: rtl/bus_cyc_pkg.sv
package bus_cyc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } bus_st_e;
endpackage

// File: rtl/bus_cyc_fsm.sv
module bus_cyc_fsm
  import bus_cyc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    rdy_n,
  output logic    req_ready,
  output logic    accept,
  output logic    term,
  output bus_st_e st
);
  bus_st_e st_nx;

  always_comb begin
    term      = (st == ST_DATA) && !rdy_n;
    req_ready = (st == ST_IDLE) || term;
    accept    = req_valid && req_ready;
  end

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: if (accept) st_nx = ST_ADDR;
      ST_ADDR: st_nx = ST_DATA;
      ST_DATA: if (term) st_nx = accept ? ST_ADDR : ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  // R2: the address state lasts one clock and leads into a data state
  a_r2_addr_then_data: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_ADDR |=> st == ST_DATA);
  // R3: ready low during the address state does not end the cycle
  a_r3_rdy_ignored_t1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ADDR && !rdy_n) |=> (st == ST_DATA && !$past(term)));
  // R4: ready high at the end of a data state repeats that state
  a_r4_wait_repeats: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA && rdy_n) |=> st == ST_DATA);
  // R10: nothing accepted on termination means idle next
  a_r10_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
    (term && !req_valid) |=> st == ST_IDLE);
  // R9: a request taken on termination starts an address state at once
  a_r9_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (term && req_valid) |=> st == ST_ADDR);
endmodule

// File: rtl/bus_cyc_dp.sv
module bus_cyc_dp #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  localparam int BE_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              term,
  input  logic              in_data,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic              req_wr,
  input  logic              req_io,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] bus_din,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [BE_W-1:0]   bus_be,
  output logic              bus_wr,
  output logic              bus_io,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_addr <= '0;
      bus_be   <= '0;
      bus_wr   <= 1'b0;
      bus_io   <= 1'b0;
      bus_dout <= '0;
    end else if (accept) begin
      bus_addr <= req_addr;
      bus_be   <= req_be;
      bus_wr   <= req_wr;
      bus_io   <= req_io;
      bus_dout <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= term;
      if (term && !bus_wr) rsp_rdata <= bus_din;
    end
  end

  assign bus_doe = in_data && bus_wr;

  // R5: request fields do not move while a data state runs
  a_r5_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
    in_data |-> ($stable(bus_addr) && $stable(bus_be) && $stable(bus_wr) && $stable(bus_io)));
  // R8: the done pulse is a single clock wide
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  // R7: read data register follows the bus on a terminating read
  a_r7_read_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (term && !bus_wr) |=> rsp_rdata == $past(bus_din));
endmodule

// File: rtl/bus_cyc_ctrl.sv
module bus_cyc_ctrl
  import bus_cyc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  localparam int BE_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic              req_wr,
  input  logic              req_io,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [BE_W-1:0]   bus_be,
  output logic              bus_wr,
  output logic              bus_io,
  output logic              bus_astb,
  output logic              bus_data_ph,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              bus_rdy_n
);
  logic    accept;
  logic    term;
  bus_st_e st;

  bus_cyc_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .rdy_n     (bus_rdy_n),
    .req_ready (req_ready),
    .accept    (accept),
    .term      (term),
    .st        (st)
  );

  assign bus_astb    = (st == ST_ADDR);
  assign bus_data_ph = (st == ST_DATA);

  bus_cyc_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .term      (term),
    .in_data   (bus_data_ph),
    .req_addr  (req_addr),
    .req_be    (req_be),
    .req_wr    (req_wr),
    .req_io    (req_io),
    .req_wdata (req_wdata),
    .bus_din   (bus_din),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wr    (bus_wr),
    .bus_io    (bus_io),
    .bus_dout  (bus_dout),
    .bus_doe   (bus_doe),
    .rsp_done  (rsp_done),
    .rsp_rdata (rsp_rdata)
  );

  // R1/R8: done only ever follows a data state
  a_r8_done_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(bus_data_ph));
  // R6: output enable only in data states
  a_r6_doe_in_data: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> bus_data_ph);
endmodule

// File: tb/test_bus_cyc_ctrl.sv
module test_bus_cyc_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;
  localparam int BE_W = DATA_W / 8;
  localparam int N_TXN = 300;

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [BE_W-1:0]   be;
    logic              wr;
    logic              io;
    logic [DATA_W-1:0] wdata;
    int                waits;
  } txn_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [BE_W-1:0] req_be = '0;
  logic req_wr = 1'b0;
  logic req_io = 1'b0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic rsp_done;
  logic [DATA_W-1:0] rsp_rdata;
  logic [ADDR_W-1:0] bus_addr;
  logic [BE_W-1:0] bus_be;
  logic bus_wr, bus_io, bus_astb, bus_data_ph, bus_doe;
  logic [DATA_W-1:0] bus_dout;
  logic [DATA_W-1:0] bus_din = '0;
  logic bus_rdy_n = 1'b1;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cyc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_bus_cyc_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_be(req_be), .req_wr(req_wr), .req_io(req_io),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wr(bus_wr), .bus_io(bus_io),
    .bus_astb(bus_astb), .bus_data_ph(bus_data_ph), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .bus_din(bus_din), .bus_rdy_n(bus_rdy_n)
  );

  function automatic logic [DATA_W-1:0] mem_word(logic [ADDR_W-1:0] a);
    return a[DATA_W-1:0] ^ {a[ADDR_W-1:ADDR_W-8], 8'h3c} ^ 16'hA55A;
  endfunction

  function automatic txn_t make_txn(int idx);
    txn_t t;
    t.addr  = ADDR_W'($urandom);
    t.be    = BE_W'($urandom);
    t.wr    = 1'($urandom);
    t.io    = 1'($urandom);
    t.wdata = DATA_W'($urandom);
    t.waits = $urandom % 6;
    case (idx)
      0: begin t.waits = 0; t.wr = 1'b0; end
      1: begin t.waits = 0; t.wr = 1'b1; end
      2: begin t.waits = 9; t.wr = 1'b0; end
      3: begin t.waits = 1; t.wr = 1'b1; end
      default: ;
    endcase
    return t;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    txn_t req, act, fin;
    bit have_req = 0, act_v = 0, fin_pend = 0, term = 0;
    bit expect_t1 = 0, expect_idle = 0, expect_data = 0;
    int issued = 0, gap = 0, t2cnt = 0, fin_t2 = 0;
    logic exp_ready;
    void'($urandom(32'd12345));

    #(CLK_PERIOD * 2 + 1);
    // R1: reset state
    check(!bus_astb && !bus_data_ph && !bus_doe && !rsp_done, "R1", "strobes in reset",
          {bus_astb, bus_data_ph, bus_doe, rsp_done}, 0);
    check(req_ready == 1'b1, "R1", "req_ready in reset", req_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;

    while (issued < N_TXN || act_v || fin_pend || have_req) begin
      @(negedge clk);
      term = 0;
      // R8: done pulse exactly one clock after termination
      check(rsp_done == fin_pend, "R8", "done pulse", rsp_done, fin_pend);
      if (fin_pend) begin
        check(fin_t2 == fin.waits + 1, "R4", "data state count", fin_t2, fin.waits + 1);
        if (!fin.wr)
          check(rsp_rdata == mem_word(fin.addr), "R7", "read data", rsp_rdata, mem_word(fin.addr));
        fin_pend = 0;
      end
      if (expect_t1) check(bus_astb == 1'b1, "R9", "address state follows accept", bus_astb, 1);
      if (expect_idle) check(!bus_astb && !bus_data_ph, "R10", "idle after cycle",
                             {bus_astb, bus_data_ph}, 0);
      if (expect_data) check(bus_data_ph && !bus_astb, "R2", "data after address",
                             {bus_astb, bus_data_ph}, 1);
      expect_t1 = 0; expect_idle = 0; expect_data = 0;

      if (bus_astb) begin
        check(act_v && !bus_data_ph, "R2", "single address state", {act_v, bus_data_ph}, 2);
        check(bus_addr == act.addr, "R5", "address in T1", bus_addr, act.addr);
        check({bus_be, bus_wr, bus_io} == {act.be, act.wr, act.io}, "R5", "controls in T1",
              {bus_be, bus_wr, bus_io}, {act.be, act.wr, act.io});
        check(!bus_doe, "R6", "doe in T1", bus_doe, 0);
        t2cnt = 0;
        expect_data = 1;
        bus_rdy_n = 1'($urandom);  // R3: random level, must be ignored
        bus_din = DATA_W'($urandom);
      end else if (bus_data_ph) begin
        t2cnt++;
        check(bus_addr == act.addr && {bus_be, bus_wr, bus_io} == {act.be, act.wr, act.io},
              "R5", "fields held in T2", bus_addr, act.addr);
        check(bus_doe == act.wr, "R6", "doe in T2", bus_doe, act.wr);
        if (act.wr) check(bus_dout == act.wdata, "R6", "write data", bus_dout, act.wdata);
        if (t2cnt - 1 >= act.waits) begin
          bus_rdy_n = 1'b0;
          bus_din = mem_word(act.addr);
          term = 1;
          fin = act; fin_t2 = t2cnt; fin_pend = 1; act_v = 0;
        end else begin
          bus_rdy_n = 1'b1;
          bus_din = ~mem_word(act.addr);
        end
      end else begin
        check(!bus_doe && !act_v, "R6", "idle outputs", {bus_doe, act_v}, 0);
        bus_rdy_n = 1'($urandom);
      end

      if (!have_req && issued < N_TXN) begin
        if (gap > 0) gap--;
        else begin req = make_txn(issued); have_req = 1; end
      end
      req_valid = have_req;
      req_addr = req.addr; req_be = req.be; req_wr = req.wr;
      req_io = req.io; req_wdata = req.wdata;
      #1;
      exp_ready = (!act_v && !bus_astb && !bus_data_ph) || term;
      check(req_ready == exp_ready, "R9", "req_ready", req_ready, exp_ready);
      if (have_req && req_ready) begin
        act = req; act_v = 1; have_req = 0; issued++;
        expect_t1 = 1;
        gap = ($urandom % 3 == 0) ? 0 : $urandom % 4;
      end else if (term) begin
        expect_idle = 1;
      end
    end
    @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule